// File: doc/BRIEF.md
# Reset-Cause and Slow-Oscillator Status Register

This block is one 32-bit control/status word inside a clock and reset controller. It keeps two sticky flags that say which of two reset causes has occurred: an option-load reset and a firewall reset. A single write-only command bit clears both flags. The word also holds the frequency range to use after leaving standby. Writes to that field take effect only while a permission input is high, and it returns to the 4 MHz code after power-on reset. Finally, the word holds the enable for a low-speed internal oscillator and its ready flag.

The oscillator itself is modelled by a start-up counter clocked by the slow clock. It runs while the enable bit is set or while any peripheral request line is active. Enable and requests are brought into the slow-clock domain through a two-flop synchronizer. Ready rises a fixed number of slow cycles after the run request arrives, and it drops three slow cycles after the request goes away. The slow-domain ready drives an output pin and is synchronized back into the register clock domain so that software can read it.

Software reaches the word through a plain register port. A write is a single-cycle strobe with the address and data. A read is combinational from the address, and any other address returns zero. There is no streaming data path, so every pin is a plain level or pulse.

Top module: `rstcause_slowosc_reg`

## Requirements
- R1: After reset the word at the register address reads 0x0000_0600, and `osc_ready` is 0.
- R2: A one-cycle pulse on `optload_rst_p` sets bit 25, and a pulse on `fwall_rst_p` sets bit 24. Each flag stays set until it is cleared. Software writes to bits 25 and 24 have no effect.
- R3: A write with bit 23 = 1 clears bits 25 and 24. A write with bit 23 = 0 leaves them unchanged. Bit 23 always reads as 0.
- R4: If a reset-cause pulse coincides with a clear write, that flag ends set, and the other flag is cleared.
- R5: Bits 11:8 take the written value only when `range_wr_allow` = 1. Otherwise a write leaves them unchanged.
- R6: Bits 31:26, 22:12 and 7:2 always read as 0.
- R7: Bit 0 is the oscillator enable. It is written and read back by software.
- R8: Count slow-clock rising edges from the first edge after the run request (enable or any `osc_req` bit) becomes 1. `osc_ready` is still 0 after edge START_CYC+1 and is 1 after edge START_CYC+2. If the request is removed during start-up, ready does not rise.
- R9: Count from the first slow edge after the run request is removed. `osc_ready` is still 1 after edge 4 and is 0 after edge 5: two synchronizer stages followed by three slow cycles. If the request returns during that countdown, ready stays high.
- R10: Any `osc_req` bit starts the oscillator and holds ready high while bit 0 is 0.
- R11: Writes to any other address leave the word unchanged, and reads of any other address return 0.
- R12: Bit 1 reads `osc_ready` after a two-flop synchronizer in the `clk` domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data; zero unless the address matches |
| optload_rst_p | input | 1 | One-cycle pulse: option-load reset occurred |
| fwall_rst_p | input | 1 | One-cycle pulse: firewall reset occurred |
| range_wr_allow | input | 1 | Permission to write the standby range field |
| osc_req | input | NREQ | Peripheral requests that keep the slow oscillator running |
| slow_clk | input | 1 | Slow oscillator clock |
| osc_ready | output | 1 | Oscillator ready, slow-clock domain |

## Verification
The bench drives a reset-cause pulse in the same cycle as a clear command. A design that gives priority to the clear would lose a reset cause that just happened. It counts slow-clock edges exactly around the rise and the fall of ready, so a missing synchronizer stage or an off-by-one start-up or stop counter shows up as a one-edge shift. It writes the range field with permission off, with permission on, and at a foreign address, so that a design ignoring the permission input or the address decode changes the field. It also starts the oscillator from a peripheral request with the enable bit at 0, cuts a start-up short, and briefly drops a request during the stop countdown, catching designs whose counter is not cleared when the run request changes.

// File: rtl/rcsr_pkg.sv
package rcsr_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned OPTLD_BIT = 25;
  localparam int unsigned FWALL_BIT = 24;
  localparam int unsigned CLR_BIT   = 23;
  localparam int unsigned RNG_LSB   = 8;
  localparam int unsigned RNG_W     = 4;
  localparam int unsigned RDY_BIT   = 1;
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned NCAUSE    = 2;

  // cause index inside the flag vector
  localparam int unsigned CAUSE_FW  = 0;
  localparam int unsigned CAUSE_OPT = 1;

  typedef enum logic [RNG_W-1:0] {
    RNG_1MHZ = 4'h4,
    RNG_2MHZ = 4'h5,
    RNG_4MHZ = 4'h6,
    RNG_8MHZ = 4'h7
  } stby_rng_e;

  localparam logic [RNG_W-1:0]  RNG_RESET = RNG_4MHZ;
  localparam logic [WORD_W-1:0] RSVD_MASK = 32'hFCFF_F0FC;
endpackage

// File: rtl/rcsr_sync.sv
module rcsr_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rcsr_flags.sv
module rcsr_flags
  import rcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] set_p,
  input  logic              clr,
  output logic [NCAUSE-1:0] flags
);
  for (genvar i = 0; i < NCAUSE; i++) begin : g_flag
    // a fresh cause outranks the clear command
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags[i] <= 1'b0;
      else if (set_p[i]) flags[i] <= 1'b1;
      else if (clr)      flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rcsr_range.sv
module rcsr_range
  import rcsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             allow,
  input  logic [RNG_W-1:0] wdata,
  output logic [RNG_W-1:0] rng
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rng <= RNG_RESET;
    else if (wr && allow) rng <= wdata;
  end
endmodule

// File: rtl/rcsr_slowosc.sv
module rcsr_slowosc #(
  parameter int unsigned NREQ        = 3,
  parameter int unsigned START_CYC   = 8,
  parameter int unsigned STOP_CYC    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            slow_clk,
  input  logic            rst_n,
  input  logic            en_async,
  input  logic [NREQ-1:0] req_async,
  output logic            ready
);
  localparam int unsigned CNT_MAX = (START_CYC > STOP_CYC) ? START_CYC : STOP_CYC;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_CYC - 1);
  localparam logic [CNT_W-1:0] STOP_LAST  = CNT_W'(STOP_CYC - 1);

  logic [NREQ:0]    src_s;
  logic             run_s;
  logic [CNT_W-1:0] cnt;

  rcsr_sync #(.W(NREQ + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (slow_clk),
    .rst_n(rst_n),
    .d    ({req_async, en_async}),
    .q    (src_s)
  );

  assign run_s = |src_s;

  // one counter serves start-up while running and shut-down while stopped
  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      cnt   <= '0;
    end else if (run_s == ready) begin
      cnt <= '0;
    end else if (run_s) begin
      if (cnt == START_LAST) begin
        ready <= 1'b1;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else begin
      if (cnt == STOP_LAST) begin
        ready <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rstcause_slowosc_reg.sv
module rstcause_slowosc_reg
  import rcsr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h94,
  parameter int unsigned NREQ        = 3,
  parameter int unsigned START_CYC   = 8,
  parameter int unsigned STOP_CYC    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              optload_rst_p,
  input  logic              fwall_rst_p,
  input  logic              range_wr_allow,
  input  logic [NREQ-1:0]   osc_req,
  input  logic              slow_clk,
  output logic              osc_ready
);
  logic              hit;
  logic              wr_hit;
  logic              en_q;
  logic              rdy_sync;
  logic [NCAUSE-1:0] cause_p;
  logic [NCAUSE-1:0] flags_q;
  logic [RNG_W-1:0]  rng_q;
  logic [WORD_W-1:0] word;
  logic              unused_wbits;

  assign hit    = (cfg_addr == REG_ADDR);
  assign wr_hit = cfg_wr && hit;

  assign cause_p[CAUSE_FW]  = fwall_rst_p;
  assign cause_p[CAUSE_OPT] = optload_rst_p;

  rcsr_flags u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .set_p(cause_p),
    .clr  (wr_hit && cfg_wdata[CLR_BIT]),
    .flags(flags_q)
  );

  rcsr_range u_range (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (wr_hit),
    .allow(range_wr_allow),
    .wdata(cfg_wdata[RNG_LSB +: RNG_W]),
    .rng  (rng_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (wr_hit) en_q <= cfg_wdata[EN_BIT];
  end

  rcsr_slowosc #(
    .NREQ       (NREQ),
    .START_CYC  (START_CYC),
    .STOP_CYC   (STOP_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_osc (
    .slow_clk (slow_clk),
    .rst_n    (rst_n),
    .en_async (en_q),
    .req_async(osc_req),
    .ready    (osc_ready)
  );

  rcsr_sync #(.W(1), .STAGES(2)) u_rdy_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (osc_ready),
    .q    (rdy_sync)
  );

  always_comb begin
    word                       = '0;
    word[OPTLD_BIT]            = flags_q[CAUSE_OPT];
    word[FWALL_BIT]            = flags_q[CAUSE_FW];
    word[RNG_LSB +: RNG_W]     = rng_q;
    word[RDY_BIT]              = rdy_sync;
    word[EN_BIT]               = en_q;
    cfg_rdata                  = hit ? word : '0;
  end

  assign unused_wbits = ^{cfg_wdata[31:24], cfg_wdata[22:12], cfg_wdata[7:1]};
endmodule

// File: rtl/rcsr_checker.sv
module rcsr_checker
  import rcsr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              slow_clk,
  input logic              wr_hit,
  input logic              clr_cmd,
  input logic              allow,
  input logic              opt_p,
  input logic              fw_p,
  input logic [NCAUSE-1:0] flags,
  input logic [RNG_W-1:0]  rng,
  input logic [31:0]       cfg_rdata,
  input logic              run_s,
  input logic              osc_ready
);
  a_r2_opt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[CAUSE_OPT] && !(wr_hit && clr_cmd)) |=> flags[CAUSE_OPT]);

  a_r2_fw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[CAUSE_FW] && !(wr_hit && clr_cmd)) |=> flags[CAUSE_FW]);

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && clr_cmd && !opt_p && !fw_p) |=> (flags == '0));

  a_r4_opt_wins: assert property (@(posedge clk) disable iff (!rst_n)
    opt_p |=> flags[CAUSE_OPT]);

  a_r4_fw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fw_p |=> flags[CAUSE_FW]);

  a_r5_range_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit && allow) |=> $stable(rng));

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_rdata & RSVD_MASK) == '0));

  a_r8_rise_needs_run: assert property (@(posedge slow_clk) disable iff (!rst_n)
    $rose(osc_ready) |-> run_s);

  a_r9_drop_delay: assert property (@(posedge slow_clk) disable iff (!rst_n)
    $fell(osc_ready) |-> (!$past(run_s, 1) && !$past(run_s, 2) && !$past(run_s, 3)));
endmodule

bind rstcause_slowosc_reg rcsr_checker u_rcsr_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .slow_clk (slow_clk),
  .wr_hit   (wr_hit),
  .clr_cmd  (cfg_wdata[23]),
  .allow    (range_wr_allow),
  .opt_p    (optload_rst_p),
  .fw_p     (fwall_rst_p),
  .flags    (flags_q),
  .rng      (rng_q),
  .cfg_rdata(cfg_rdata),
  .run_s    (u_osc.run_s),
  .osc_ready(osc_ready)
);

// File: tb/test_rstcause_slowosc_reg.sv
module test_rstcause_slowosc_reg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [7:0]  RA     = 8'h94;
  localparam int unsigned NREQ   = 3;
  localparam int unsigned START  = 8;

  logic              clk = 1'b0;
  logic              slow_clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = RA;
  logic              cfg_wr = 1'b0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic              optload_rst_p = 1'b0;
  logic              fwall_rst_p = 1'b0;
  logic              range_wr_allow = 1'b0;
  logic [NREQ-1:0]   osc_req = '0;
  logic              osc_ready;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];
  event rd_ev;

  always #4 clk = ~clk;
  initial begin
    #2;
    forever #64 slow_clk = ~slow_clk;
  end

  rstcause_slowosc_reg #(
    .ADDR_W(ADDR_W), .REG_ADDR(RA), .NREQ(NREQ), .START_CYC(START)
  ) i_rstcause_slowosc_reg (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .optload_rst_p(optload_rst_p), .fwall_rst_p(fwall_rst_p),
    .range_wr_allow(range_wr_allow), .osc_req(osc_req),
    .slow_clk(slow_clk), .osc_ready(osc_ready)
  );

  // monitor: compare each read against the next scoreboard entry
  initial begin
    exp_t e;
    forever begin
      @(rd_ev);
      e = sb_q.pop_front();
      checks++;
      if (cfg_rdata !== e.exp) begin
        errors++;
        $display("FAIL %s: rdata=%h expected %h", e.tag, cfg_rdata, e.exp);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    sb_q.push_back('{exp: exp, tag: tag});
    #1 -> rd_ev;
    #1 cfg_addr = RA;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic allow);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1; range_wr_allow = allow;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_addr = RA; range_wr_allow = 1'b0;
  endtask

  task automatic pulse(input logic opt, input logic fw);
    @(negedge clk);
    optload_rst_p = opt; fwall_rst_p = fw;
    @(negedge clk);
    optload_rst_p = 1'b0; fwall_rst_p = 1'b0;
  endtask

  task automatic chk_rdy(input logic exp, input string tag);
    checks++;
    if (osc_ready !== exp) begin
      errors++;
      $display("FAIL %s: osc_ready=%b expected %b", tag, osc_ready, exp);
    end
  endtask

  task automatic slow_edges(input int n);
    repeat (n) @(posedge slow_clk);
    #1;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_600_000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(RA, 32'h0000_0600, "R1 reset word");
    chk_rdy(1'b0, "R1 ready after reset");

    // R2/R3/R5/R6: all ones except enable, no permission
    wr(RA, 32'hFFFF_FFFE, 1'b0);
    rd(RA, 32'h0000_0600, "R6 reserved, R2 sw flags, R3 cmd reads 0, R5 guarded");

    // R5 permitted writes
    wr(RA, 32'h0000_0400, 1'b1);
    rd(RA, 32'h0000_0400, "R5 range 1MHz code");
    wr(RA, 32'h0000_0700, 1'b1);
    rd(RA, 32'h0000_0700, "R5 range 8MHz code");

    // R11 foreign address
    wr(8'h90, 32'h0000_0501, 1'b1);
    rd(RA, 32'h0000_0700, "R11 foreign write ignored");
    rd(8'h90, 32'h0000_0000, "R11 foreign read zero");

    // R2 sticky cause flags
    pulse(1'b1, 1'b0);
    rd(RA, 32'h0200_0700, "R2 option-load flag");
    pulse(1'b0, 1'b1);
    rd(RA, 32'h0300_0700, "R2 firewall flag");
    wr(RA, 32'h0000_0700, 1'b0);
    rd(RA, 32'h0300_0700, "R3 write of 0 keeps flags");

    // R3 clear
    wr(RA, 32'h0080_0700, 1'b0);
    rd(RA, 32'h0000_0700, "R3 clear command");

    // R4 pulse beats clear
    pulse(1'b0, 1'b1);
    @(negedge clk);
    cfg_wdata = 32'h0080_0700; cfg_wr = 1'b1; optload_rst_p = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; optload_rst_p = 1'b0;
    rd(RA, 32'h0200_0700, "R4 coincident pulse wins");
    wr(RA, 32'h0080_0700, 1'b0);
    rd(RA, 32'h0000_0700, "R3 clear after R4");

    // R8 start-up timing from enable
    wr(RA, 32'h0000_0701, 1'b0);
    slow_edges(START + 1);
    chk_rdy(1'b0, "R8 not yet ready");
    slow_edges(1);
    chk_rdy(1'b1, "R8 ready edge");
    repeat (4) @(negedge clk);
    rd(RA, 32'h0000_0703, "R12 R7 ready and enable readback");

    // R9 stop timing
    wr(RA, 32'h0000_0700, 1'b0);
    slow_edges(4);
    chk_rdy(1'b1, "R9 still ready at edge 4");
    slow_edges(1);
    chk_rdy(1'b0, "R9 dropped at edge 5");
    repeat (4) @(negedge clk);
    rd(RA, 32'h0000_0700, "R12 ready bit cleared");

    // R10 request with enable off
    @(negedge slow_clk);
    osc_req = 3'b010;
    slow_edges(START + 1);
    chk_rdy(1'b0, "R10 request start-up pending");
    slow_edges(1);
    chk_rdy(1'b1, "R10 request ready");
    repeat (4) @(negedge clk);
    rd(RA, 32'h0000_0702, "R10 ready with enable 0");

    // R9 request returns during countdown
    @(negedge slow_clk);
    osc_req = 3'b000;
    @(negedge slow_clk);
    osc_req = 3'b100;
    slow_edges(8);
    chk_rdy(1'b1, "R9 countdown cancelled");

    @(negedge slow_clk);
    osc_req = 3'b000;
    slow_edges(4);
    chk_rdy(1'b1, "R9 request drop edge 4");
    slow_edges(1);
    chk_rdy(1'b0, "R9 request drop edge 5");

    // R8 aborted start-up
    wr(RA, 32'h0000_0701, 1'b0);
    slow_edges(5);
    wr(RA, 32'h0000_0700, 1'b0);
    slow_edges(START + 6);
    chk_rdy(1'b0, "R8 aborted start-up stays low");

    finish_run();
  end
endmodule